// File: doc/BRIEF.md
# Sample Timer and Backup Sequencer

This block paces the output side of a sensor. A free-running interval timer, counted from the system clock, marks the end of each sample cycle. At that point the block copies the incoming sample words into its output registers. One clock later it raises a data-ready strobe for a single cycle, so a host interrupt handler never sees the strobe while the registers are still changing. The interval is a base count multiplied by (period setting + 1). The base count is chosen so that a setting of zero gives the default rate of 819.2 samples per second at the nominal system clock.

The block also runs a user-triggered backup. A command strobe starts a long copy with a fixed duration of 50 ms at the nominal clock. Busy stays high for the whole copy. When the copy ends, the writable user configuration is written into a nonvolatile shadow store, modelled here as a register array, and a backup event counter steps by one. Command strobes that arrive while busy is high are dropped. Sampling carries on while a backup runs.

Top module: `sbs_ctrl`

## Requirements
- R1: While reset is asserted and at reset release, the output registers, data-ready, busy, the backup counter and the shadow store all read zero.
- R2: Output-register loads are spaced BASE_CLKS*(period_sel+1) clock cycles apart. The first load comes on the BASE_CLKS*(period_sel+1)-th rising edge after reset release. With period_sel = 0 this is the default 819.2 samples/s rate at the nominal clock.
- R3: On a load edge the output registers take the sample_in value present at that edge. Data-ready is high in the clock cycle that follows the load cycle, never in the load cycle itself.
- R4: Data-ready stays high for exactly one clock cycle, and the output registers hold their value while it is high.
- R5: When busy is low, a backup_cmd high at a rising edge sets busy from that edge on. Busy then stays high for exactly BACKUP_CLKS cycles.
- R6: On the edge where busy falls, the shadow store takes the user_cfg value present at that edge and the backup counter increments by one. The shadow store and the counter do not change at any other time.
- R7: A backup_cmd that arrives while busy is high has no effect. The busy window is not restarted or lengthened, and the completed backup adds exactly one to the counter.
- R8: A running backup does not disturb the sample timing or the data-ready strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_sel | input | PRD_W | Sample-period setting; the interval is BASE_CLKS*(value+1) |
| backup_cmd | input | 1 | Backup request strobe |
| sample_in | input | NUM_CH*DATA_W | Incoming sample words, channel 0 in the low bits |
| user_cfg | input | NUM_USR*USR_W | Writable user configuration to be backed up |
| out_regs | output | NUM_CH*DATA_W | Latched output registers |
| drdy | output | 1 | One-cycle data-ready strobe, high the cycle after a load |
| busy | output | 1 | High while a backup is in progress |
| backup_count | output | CNT_W | Number of completed backups since reset |
| shadow_out | output | NUM_USR*USR_W | Contents of the nonvolatile shadow store |

## Verification
The bench measures the gap between every pair of data-ready strobes, and the gap from reset release to the first one, for two period settings. A timer with an off-by-one limit, or one that ignores the period setting, produces gaps one cycle off or a fixed gap. Every strobe is compared against the sample word present at the load edge, and against the register value one cycle earlier. A strobe issued in the load cycle itself, or held for two cycles, therefore shows up as stale data or as a doubled strobe. A second command is issued halfway through each backup. A sequencer that restarts on it shows a long busy window, and one that counts it shows a count that jumps by two. The shadow store is also read in the middle of the copy, which exposes a copy made at the start rather than at completion.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   typedef enum logic {
      BK_IDLE = 1'b0,
      BK_COPY = 1'b1
   } bk_state_t;
endpackage

// File: rtl/sbs_sample_timer.sv
module sbs_sample_timer #(
   parameter int BASE_CLKS = 152588,
   parameter int PRD_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRD_W-1:0] period_sel,
   output logic             tick
);
   localparam longint MAX_LIM = longint'(BASE_CLKS) * (longint'(1) << PRD_W);
   localparam int     CW      = $clog2(MAX_LIM + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb begin
      lim  = CW'(BASE_CLKS) * (CW'(period_sel) + CW'(1));
      tick = (cnt >= lim - CW'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + CW'(1);
   end

   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/sbs_out_latch.sv
module sbs_out_latch #(
   parameter int NUM_CH = 6,
   parameter int DATA_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [NUM_CH*DATA_W-1:0] sample_in,
   output logic [NUM_CH*DATA_W-1:0] out_regs,
   output logic                     drdy
);
   logic load_d;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    out_regs[ch*DATA_W +: DATA_W] <= '0;
         else if (load) out_regs[ch*DATA_W +: DATA_W] <= sample_in[ch*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_d <= 1'b0;
         drdy   <= 1'b0;
      end else begin
         load_d <= load;
         drdy   <= load_d;
      end
   end

   p_drdy_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      drdy |-> $past(load, 2) && !$past(load));
   p_drdy_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      drdy |-> $stable(out_regs));
   p_drdy_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      drdy |=> !drdy);
endmodule

// File: rtl/sbs_backup_seq.sv
module sbs_backup_seq
   import sbs_pkg::*;
#(
   parameter int NUM_USR     = 4,
   parameter int USR_W       = 8,
   parameter int BACKUP_CLKS = 6250000,
   parameter int CNT_W       = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd,
   input  logic [NUM_USR*USR_W-1:0] user_cfg,
   output logic                     busy,
   output logic [CNT_W-1:0]         count,
   output logic [NUM_USR*USR_W-1:0] shadow
);
   localparam int TW = $clog2(BACKUP_CLKS + 1);

   bk_state_t     state;
   logic [TW-1:0] tmr;
   logic          done;

   assign busy = (state == BK_COPY);
   assign done = busy && (tmr == TW'(BACKUP_CLKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= BK_IDLE;
         tmr   <= '0;
         count <= '0;
      end else begin
         case (state)
            BK_IDLE: if (cmd) begin
               state <= BK_COPY;
               tmr   <= '0;
            end
            BK_COPY: if (done) begin
               state <= BK_IDLE;
               count <= count + CNT_W'(1);
            end else begin
               tmr <= tmr + TW'(1);
            end
            default: state <= BK_IDLE;
         endcase
      end
   end

   for (genvar w = 0; w < NUM_USR; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    shadow[w*USR_W +: USR_W] <= '0;
         else if (done) shadow[w*USR_W +: USR_W] <= user_cfg[w*USR_W +: USR_W];
      end
   end

   p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd) |=> busy);
   p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> count == $past(count) + CNT_W'(1));
   p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(busy) |-> $stable(count) && $stable(shadow));
   p_cmd_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd && !done) |=> busy && $stable(count));
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl #(
   parameter int BASE_CLKS   = 152588,
   parameter int PRD_W       = 8,
   parameter int NUM_CH      = 6,
   parameter int DATA_W      = 16,
   parameter int NUM_USR     = 4,
   parameter int USR_W       = 8,
   parameter int BACKUP_CLKS = 6250000,
   parameter int CNT_W       = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [PRD_W-1:0]         period_sel,
   input  logic                     backup_cmd,
   input  logic [NUM_CH*DATA_W-1:0] sample_in,
   input  logic [NUM_USR*USR_W-1:0] user_cfg,
   output logic [NUM_CH*DATA_W-1:0] out_regs,
   output logic                     drdy,
   output logic                     busy,
   output logic [CNT_W-1:0]         backup_count,
   output logic [NUM_USR*USR_W-1:0] shadow_out
);
   if (BASE_CLKS < 3) begin : g_bad_base
      $error("BASE_CLKS must be at least 3");
   end
   if (BACKUP_CLKS < 2) begin : g_bad_backup
      $error("BACKUP_CLKS must be at least 2");
   end
   if (PRD_W < 1 || PRD_W > 16) begin : g_bad_prd
      $error("PRD_W out of range");
   end
   if (NUM_CH < 1 || NUM_USR < 1 || CNT_W < 1) begin : g_bad_size
      $error("channel, word and counter sizes must be positive");
   end

   logic tick;

   sbs_sample_timer #(
      .BASE_CLKS (BASE_CLKS),
      .PRD_W     (PRD_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .period_sel (period_sel),
      .tick       (tick)
   );

   sbs_out_latch #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W)
   ) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tick),
      .sample_in (sample_in),
      .out_regs  (out_regs),
      .drdy      (drdy)
   );

   sbs_backup_seq #(
      .NUM_USR     (NUM_USR),
      .USR_W       (USR_W),
      .BACKUP_CLKS (BACKUP_CLKS),
      .CNT_W       (CNT_W)
   ) u_backup (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (backup_cmd),
      .user_cfg (user_cfg),
      .busy     (busy),
      .count    (backup_count),
      .shadow   (shadow_out)
   );

   p_drdy_not_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      drdy |-> !tick);
endmodule

// File: tb/sbs_ctrl_bench.sv
module sbs_ctrl_bench;
   localparam int BASE = 8;
   localparam int BK   = 40;
   localparam int NCH  = 6;
   localparam int DW   = 16;
   localparam int NU   = 4;
   localparam int UW   = 8;
   localparam int CW   = 16;
   localparam int SW   = NCH*DW;
   localparam int UCW  = NU*UW;

   typedef struct {
      logic [CW-1:0]  cnt;
      logic [UCW-1:0] shd;
   } bk_item_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [7:0]     period_sel = '0;
   logic           backup_cmd = 1'b0;
   logic [SW-1:0]  samp = '0;
   logic [UCW-1:0] user_cfg = '0;
   logic [SW-1:0]  out_regs;
   logic           drdy;
   logic           busy;
   logic [CW-1:0]  backup_count;
   logic [UCW-1:0] shadow_out;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int gapq[$];
   bk_item_t bkq[$];

   always #4 clk = ~clk;

   sbs_ctrl #(
      .BASE_CLKS (BASE), .PRD_W (8), .NUM_CH (NCH), .DATA_W (DW),
      .NUM_USR (NU), .USR_W (UW), .BACKUP_CLKS (BK), .CNT_W (CW)
   ) u_sbs_ctrl (
      .clk (clk), .rst_n (rst_n), .period_sel (period_sel),
      .backup_cmd (backup_cmd), .sample_in (samp), .user_cfg (user_cfg),
      .out_regs (out_regs), .drdy (drdy), .busy (busy),
      .backup_count (backup_count), .shadow_out (shadow_out)
   );

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor and sample driver
   int          since = 0;
   int          busy_len = 0;
   bit          prev_busy = 0;
   bit          prev_drdy = 0;
   logic [SW-1:0] prev_samp = '0;
   logic [SW-1:0] prev_out = '0;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         since = 0; busy_len = 0; prev_busy = 0; prev_drdy = 0;
      end else begin
         since++;
         if (drdy) begin
            if (gapq.size() > 0) begin
               int g;
               g = gapq.pop_front();
               chk(since == g, "R2 R8 strobe spacing", since, g);
               chk(out_regs == prev_samp, "R3 loaded sample", out_regs, prev_samp);
               chk(!prev_drdy && out_regs == prev_out, "R4 single strobe, stable data",
                   {prev_drdy, out_regs}, {1'b0, prev_out});
            end
            since = 0;
         end
         if (busy) busy_len++;
         if (prev_busy && !busy) begin
            bk_item_t it;
            chk(busy_len == BK, "R5 R7 busy length", busy_len, BK);
            if (bkq.size() > 0) begin
               it = bkq.pop_front();
               chk(backup_count == it.cnt, "R6 R7 backup count", backup_count, it.cnt);
               chk(shadow_out == it.shd, "R6 shadow copy", shadow_out, it.shd);
            end
            busy_len = 0;
         end
         prev_busy = busy;
         prev_drdy = drdy;
      end
      prev_out  = out_regs;
      prev_samp = samp;
      for (int c = 0; c < NCH; c++)
         samp[c*DW +: DW] = DW'(cyc * 13 + c * 16'h1357);
   end

   always @(negedge clk) begin
      if (cyc > 20000) begin
         chk(1'b0, "watchdog expired", cyc, 20000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic check_reset();
      chk(out_regs == '0 && !drdy && !busy && backup_count == '0 && shadow_out == '0,
          "R1 reset state", {out_regs, drdy, busy, backup_count}, '0);
   endtask

   task automatic do_reset(input logic [7:0] prd);
      @(negedge clk); #1 rst_n = 1'b0; period_sel = prd;
      gapq.delete(); bkq.delete();
      repeat (3) @(negedge clk);
      check_reset();
      #1 rst_n = 1'b1;
   endtask

   task automatic do_backup(input logic [UCW-1:0] cfg, input logic [UCW-1:0] old_shd,
                            input logic [CW-1:0] exp_cnt);
      bk_item_t it;
      it.cnt = exp_cnt; it.shd = cfg;
      bkq.push_back(it);
      @(negedge clk); #1 user_cfg = cfg; backup_cmd = 1'b1;
      @(negedge clk); #1 backup_cmd = 1'b0;
      repeat (15) @(negedge clk);
      chk(shadow_out == old_shd && busy, "R6 shadow holds mid-copy", shadow_out, old_shd);
      #1 backup_cmd = 1'b1;   // R7: must be dropped
      @(negedge clk); #1 backup_cmd = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      // phase 1: period 0
      do_reset(8'd0);
      check_reset();
      gapq.push_back(BASE + 1);
      for (int i = 0; i < 7; i++) gapq.push_back(BASE);
      do_backup(32'hA5C3_1F0E, '0, 16'd1);
      while (gapq.size() > 0 || bkq.size() > 0) @(negedge clk);

      // phase 2: period 2, two backups
      do_reset(8'd2);
      gapq.push_back(3*BASE + 1);
      for (int i = 0; i < 3; i++) gapq.push_back(3*BASE);
      do_backup(32'h0123_7788, '0, 16'd1);
      do_backup(32'hFEDC_0042, 32'h0123_7788, 16'd2);
      while (gapq.size() > 0 || bkq.size() > 0) @(negedge clk);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule